// File: doc/BRIEF.md
# Gen3 Link Equalization Phase Sequencer

This block steps one link through the four equalization phases used at 8 GT/s. It can run as the upstream side or as the downstream side of the link. Each lane supplies the equalization-control (EC) code decoded from its incoming training sets, along with a flag that marks the decode as valid. Two further inputs set behaviour: a lane mask that names the active lanes, and a tuning-done indication for the optional fine-tuning phases. The block reports the current phase and the EC code to place in outgoing training sets. When it finishes, it raises a level that hands the link on to receiver lock.

An EC code does not count on the cycle it first appears. It must be seen on a lane for a programmable number of consecutive cycles. Upstream needs every active lane to qualify before it advances. Downstream moves as soon as any active lane qualifies. Phases 2 and 3 can be bypassed, and each is then visited for exactly one cycle. A per-phase timer ends a stalled sequence at receiver lock and flags the failure.

Top module: `eq_phase_seq`

## Requirements
- R1: After reset, phase is 0, eqActive is 0, txEc is 2'b00, exitToLock is 0 and eqFailed is 0.
- R2: A high startEq while the block is idle or finished enters phase 0 on the next clock edge. eqActive is then 1 and eqFailed is cleared. A high startEq during phases 0 to 3 has no effect.
- R3: While active, the phase output only holds or rises by one per cycle, so it visits 0, 1, 2 and 3 in that order.
- R4: A lane qualifies for code X after qualThresh consecutive cycles (qualThresh of 1 or more) in which laneValid is high and its 2-bit field laneEc[2i+1:2i] equals X. A cycle without a match restarts that lane's count. The phase moves on the clock edge that follows qualification.
- R5: In the upstream role (isUpstream=1), phase 0 waits for code 2'b00 and phase 1 waits for code 2'b01. Each advances only when every lane set in laneMask has qualified. Lanes cleared in the mask are ignored. An all-zero mask never advances.
- R6: In the downstream role, phase 0 advances on code 2'b01 and phase 1 advances on code 2'b10. In each case, one qualified active lane is enough.
- R7: While active, txEc equals the phase number (2'b10 in phase 2). Once the sequence is finished, txEc is 2'b00.
- R8: With skipTune=0, phases 2 and 3 each wait for tuneDone. With skipTune=1, each lasts exactly one cycle.
- R9: The edge after phase 3 completes moves the block to finished. In that state exitToLock=1, eqActive=0 and eqFailed=0.
- R10: If a phase does not advance within timeoutLimit+1 cycles of entry, the next edge moves the block to finished. exitToLock and eqFailed are then both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isUpstream | input | 1 | 1 selects the upstream role, 0 the downstream role |
| skipTune | input | 1 | Bypass phases 2 and 3 |
| startEq | input | 1 | Begin equalization (phase 0 entry) |
| laneMask | input | NUM_LANES | Active lanes |
| laneValid | input | NUM_LANES | Per-lane training-set decode valid |
| laneEc | input | 2*NUM_LANES | Per-lane decoded EC code, lane i at bits 2i+1:2i |
| tuneDone | input | 1 | Coefficient tuning finished for phase 2 or 3 |
| qualThresh | input | QUAL_W | Consecutive matches needed to qualify a lane |
| timeoutLimit | input | TIMER_W | Per-phase timeout in cycles |
| phase | output | 2 | Current equalization phase |
| eqActive | output | 1 | Sequence in phases 0 to 3 |
| txEc | output | 2 | EC code to transmit |
| exitToLock | output | 1 | Sequence finished, go to receiver lock |
| eqFailed | output | 1 | Sequence ended by timeout |

## Verification
A wrong expected code or a broken lane count shows up as the phase output changing at the wrong edge. The phase either moves earlier or later than qualThresh+1 cycles after the matching codes begin, or it never moves at all. The bench measures that edge exactly, across every threshold, role and nonzero lane mask. A corrupted state or timer becomes visible within one cycle at txEc, exitToLock or eqFailed, because all of them follow the registered state directly.

// File: rtl/eq_seq_pkg.sv
package eq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PH0, S_PH1, S_PH2, S_PH3, S_DONE
  } eqState_t;

  typedef struct packed {
    logic       clrQual;
    logic       clrTimer;
    logic [1:0] expCode;
  } eqStrobe_t;
endpackage

// File: rtl/eq_seq_datapath.sv
module eq_seq_datapath
  import eq_seq_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int QUAL_W    = 4,
  parameter int TIMER_W   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  eqStrobe_t              strobe,
  input  logic [2*NUM_LANES-1:0] laneEc,
  input  logic [NUM_LANES-1:0]   laneValid,
  input  logic [NUM_LANES-1:0]   laneMask,
  input  logic [QUAL_W-1:0]      qualThresh,
  input  logic [TIMER_W-1:0]     timeoutLimit,
  output logic                   anyQual,
  output logic                   allQual,
  output logic                   timedOut
);
  localparam logic [QUAL_W-1:0]  QMAX = {QUAL_W{1'b1}};
  localparam logic [TIMER_W-1:0] TMAX = {TIMER_W{1'b1}};

  logic [NUM_LANES-1:0] laneQual;
  logic [TIMER_W-1:0]   timer;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [QUAL_W-1:0] cnt;
    logic              match;
    assign match = laneValid[g] && (laneEc[2*g +: 2] == strobe.expCode);
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrQual || !match) cnt <= '0;
      else if (cnt != QMAX)                   cnt <= cnt + 1'b1;
    end
    assign laneQual[g] = laneMask[g] && (cnt >= qualThresh);
  end

  assign anyQual = |laneQual;
  assign allQual = (|laneMask) && (&(laneQual | ~laneMask));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrTimer) timer <= '0;
    else if (timer != TMAX)       timer <= timer + 1'b1;
  end
  assign timedOut = (timer >= timeoutLimit);

  AST_QUAL_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.clrQual) && qualThresh != '0) |-> !anyQual); // R4
endmodule

// File: rtl/eq_seq_ctrl.sv
module eq_seq_ctrl
  import eq_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      isUpstream,
  input  logic      skipTune,
  input  logic      startEq,
  input  logic      tuneDone,
  input  logic      anyQual,
  input  logic      allQual,
  input  logic      timedOut,
  output eqStrobe_t strobe,
  output logic [1:0] phase,
  output logic      eqActive,
  output logic      txEc,
  output logic      txEcHi,
  output logic      exitToLock,
  output logic      eqFailed
);
  eqState_t curState, nextState;
  logic     failNow;
  logic     qualOk;

  assign qualOk = isUpstream ? allQual : anyQual;

  always_comb begin
    nextState = curState;
    failNow   = 1'b0;
    unique case (curState)
      S_IDLE, S_DONE: if (startEq) nextState = S_PH0;
      S_PH0: begin
        if (qualOk)        nextState = S_PH1;
        else if (timedOut) failNow = 1'b1;
      end
      S_PH1: begin
        if (qualOk)        nextState = S_PH2;
        else if (timedOut) failNow = 1'b1;
      end
      S_PH2: begin
        if (skipTune || tuneDone) nextState = S_PH3;
        else if (timedOut)        failNow = 1'b1;
      end
      S_PH3: begin
        if (skipTune || tuneDone) nextState = S_DONE;
        else if (timedOut)        failNow = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
    if (failNow) nextState = S_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= S_IDLE;
      eqFailed <= 1'b0;
    end else begin
      curState <= nextState;
      if (failNow)                                    eqFailed <= 1'b1;
      else if (nextState == S_PH0 && curState != S_PH0) eqFailed <= 1'b0;
    end
  end

  always_comb begin
    unique case (curState)
      S_PH1:   phase = 2'd1;
      S_PH2:   phase = 2'd2;
      S_PH3:   phase = 2'd3;
      default: phase = 2'd0;
    endcase
  end

  assign eqActive   = (curState == S_PH0) || (curState == S_PH1) ||
                      (curState == S_PH2) || (curState == S_PH3);
  assign exitToLock = (curState == S_DONE);
  assign txEc       = eqActive & phase[0];
  assign txEcHi     = eqActive & phase[1];

  assign strobe.clrQual  = (nextState != curState) || !eqActive;
  assign strobe.clrTimer = (nextState != curState) || !eqActive;
  assign strobe.expCode  = isUpstream ? phase : phase + 2'd1;

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (eqActive && $past(eqActive)) |->
      (phase == $past(phase) || phase == $past(phase) + 2'd1)); // R3
  AST_EXIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    exitToLock |-> (!eqActive && !txEc && !txEcHi)); // R9
  AST_FAIL_AT_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    eqFailed |-> exitToLock); // R10
  AST_SKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (curState == S_PH2 && skipTune) |=> (curState == S_PH3)); // R8
endmodule

// File: rtl/eq_phase_seq.sv
module eq_phase_seq
  import eq_seq_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int QUAL_W    = 4,
  parameter int TIMER_W   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   isUpstream,
  input  logic                   skipTune,
  input  logic                   startEq,
  input  logic [NUM_LANES-1:0]   laneMask,
  input  logic [NUM_LANES-1:0]   laneValid,
  input  logic [2*NUM_LANES-1:0] laneEc,
  input  logic                   tuneDone,
  input  logic [QUAL_W-1:0]      qualThresh,
  input  logic [TIMER_W-1:0]     timeoutLimit,
  output logic [1:0]             phase,
  output logic                   eqActive,
  output logic [1:0]             txEc,
  output logic                   exitToLock,
  output logic                   eqFailed
);
  eqStrobe_t strobe;
  logic      anyQual, allQual, timedOut;
  logic      txEcLo, txEcHi;

  eq_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .isUpstream(isUpstream), .skipTune(skipTune),
    .startEq(startEq), .tuneDone(tuneDone), .anyQual(anyQual),
    .allQual(allQual), .timedOut(timedOut), .strobe(strobe), .phase(phase),
    .eqActive(eqActive), .txEc(txEcLo), .txEcHi(txEcHi),
    .exitToLock(exitToLock), .eqFailed(eqFailed)
  );

  eq_seq_datapath #(.NUM_LANES(NUM_LANES), .QUAL_W(QUAL_W), .TIMER_W(TIMER_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .laneEc(laneEc),
    .laneValid(laneValid), .laneMask(laneMask), .qualThresh(qualThresh),
    .timeoutLimit(timeoutLimit), .anyQual(anyQual), .allQual(allQual),
    .timedOut(timedOut)
  );

  assign txEc = {txEcHi, txEcLo};
endmodule

// File: tb/eq_phase_seq_bench.sv
module eq_phase_seq_bench;
  localparam int NL = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0, isUpstream = 1'b0, skipTune = 1'b0, startEq = 1'b0, tuneDone = 1'b0;
  logic [NL-1:0]   laneMask = '1, laneValid = '0;
  logic [2*NL-1:0] laneEc = '0;
  logic [3:0]      qualThresh = 4'd2;
  logic [15:0]     timeoutLimit = 16'd1000;
  logic [1:0] phase, txEc;
  logic eqActive, exitToLock, eqFailed;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  eq_phase_seq u_eq_phase_seq (
    .clk(clk), .rstN(rstN), .isUpstream(isUpstream), .skipTune(skipTune),
    .startEq(startEq), .laneMask(laneMask), .laneValid(laneValid),
    .laneEc(laneEc), .tuneDone(tuneDone), .qualThresh(qualThresh),
    .timeoutLimit(timeoutLimit), .phase(phase), .eqActive(eqActive),
    .txEc(txEc), .exitToLock(exitToLock), .eqFailed(eqFailed)
  );

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; startEq = 1'b0; tuneDone = 1'b0; tick(); tick(); rstN = 1'b1;
  endtask

  task automatic start(); startEq = 1'b1; tick(); startEq = 1'b0; endtask

  // every lane carries code c, valid on lanes in v
  task automatic drive(logic [1:0] c, logic [NL-1:0] v);
    laneValid = v;
    for (int i = 0; i < NL; i++) laneEc[2*i +: 2] = c;
  endtask

  task automatic ticksToPhase(int target, int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (n == 0 && phase == target[1:0]) n = i;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    doReset();
    // R1 reset state
    chk("R1 phase", phase, 0); chk("R1 eqActive", eqActive, 0);
    chk("R1 txEc", txEc, 0); chk("R1 exit", exitToLock, 0); chk("R1 failed", eqFailed, 0);

    // R4 R5 R6 sweep: threshold x role x nonzero mask
    for (int th = 1; th <= 4; th++)
      for (int up = 0; up <= 1; up++)
        for (int m = 1; m < 16; m++) begin
          int low = 0;
          for (int b = 3; b >= 0; b--) if (m[b]) low = b;
          qualThresh = th[3:0]; isUpstream = up[0]; laneMask = m[3:0];
          doReset(); start();
          chk("R2 enter phase0", eqActive, 1);
          if (up == 1) drive(2'b00, m[3:0]);
          else drive(2'b01, 4'(1 << low));
          ticksToPhase(1, th + 3, n);
          chk(up == 1 ? "R5 up all-lanes timing" : "R6 down any-lane timing", n, th + 1);
        end

    // R5 one active lane missing blocks upstream
    qualThresh = 3; isUpstream = 1'b1; laneMask = 4'b1011;
    doReset(); start(); drive(2'b00, 4'b1010);
    ticksToPhase(1, 8, n);
    chk("R5 missing lane holds phase", phase, 0);
    // R5 masked-out lane ignored
    drive(2'b00, 4'b1011); laneEc[5:4] = 2'b11;
    ticksToPhase(1, 6, n);
    chk("R5 masked lane ignored", n, 4);
    // R5 empty mask never advances
    laneMask = 4'b0000; doReset(); start(); drive(2'b00, 4'b1111);
    ticksToPhase(1, 10, n);
    chk("R5 empty mask", phase, 0);

    // R4 break restarts count (downstream, th=3)
    laneMask = 4'b1111; isUpstream = 1'b0; doReset(); start();
    drive(2'b01, 4'b0001); tick(); tick();
    drive(2'b01, 4'b0000); tick();
    chk("R4 no early advance", phase, 0);
    drive(2'b01, 4'b0001);
    ticksToPhase(1, 6, n);
    chk("R4 restart count", n, 4);
    // R7 txEc in phase1, R2 start ignored while active
    chk("R7 txEc phase1", txEc, 1);
    startEq = 1'b1; tick(); startEq = 1'b0;
    chk("R2 start ignored", phase, 1);
    // R6 code 10 -> phase2
    drive(2'b10, 4'b0100);
    ticksToPhase(2, 6, n);
    chk("R6 phase2 timing", n, 4);
    chk("R7 txEc phase2", txEc, 2);
    // R8 waiting for tuneDone
    for (int k = 0; k < 5; k++) tick();
    chk("R8 phase2 waits", phase, 2);
    tuneDone = 1'b1; tick();
    chk("R8 phase3 on tuneDone", phase, 3);
    chk("R7 txEc phase3", txEc, 3);
    tuneDone = 1'b0; tick(); tick();
    chk("R8 phase3 waits", phase, 3);
    tuneDone = 1'b1; tick(); tuneDone = 1'b0;
    chk("R9 exit", exitToLock, 1); chk("R9 inactive", eqActive, 0);
    chk("R9 no fail", eqFailed, 0); chk("R7 txEc done", txEc, 0);

    // R8 skip: upstream, phases 2 and 3 one cycle each
    isUpstream = 1'b1; skipTune = 1'b1; qualThresh = 1;
    start(); drive(2'b00, 4'b1111); tick(); tick();
    chk("R3 phase1", phase, 1);
    drive(2'b01, 4'b1111); tick(); tick();
    chk("R8 skip phase2", phase, 2); tick();
    chk("R8 skip phase3", phase, 3); tick();
    chk("R9 skip exit", exitToLock, 1);
    skipTune = 1'b0;

    // R10 timeout of 20 cycles in phase0
    timeoutLimit = 16'd20; drive(2'b11, 4'b0000);
    start();
    for (int k = 0; k < 20; k++) tick();
    chk("R10 still phase0", eqActive, 1);
    tick();
    chk("R10 exit on timeout", exitToLock, 1);
    chk("R10 failed", eqFailed, 1);
    // R2 restart clears failure
    start();
    chk("R2 restart clears fail", eqFailed, 0);
    chk("R2 restart active", eqActive, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule